// File: doc/BRIEF.md
# Serial MSB-First Maximum Selector

This block takes two unsigned numbers presented side by side as bit streams, one bit of each per accepted cycle, most significant bit first, and streams out the larger of the two, bit by bit, in the same order. It does this with a small three-state machine. The machine stays in a tie state while the two prefixes seen so far match. At the first bit position where the operands differ, it locks onto the operand that holds the 1 and passes that operand's bits through from then on.

A start pulse opens a new comparison. If an input bit is accepted in the same cycle as the start pulse, that bit is the first bit of the new comparison. Cycles without input valid leave the machine unchanged and produce no output. Each output bit appears, registered, one cycle after its input pair is accepted.

Top module: `serial_max_sel`

## Requirements
- R1: After a synchronous reset, out_valid is 0 and the machine is in the tie state.
- R2: out_valid is 1 exactly in the cycle after a cycle with in_valid high, and 0 otherwise.
- R3: In the tie state, input pair (a,b) = (0,0) or (1,1) gives z equal to that common bit, and the machine stays in the tie state.
- R4: In the tie state, a=1 with b=0 gives z=1 and locks onto a. From then on, z equals a for every accepted bit.
- R5: In the tie state, a=0 with b=1 gives z=1 and locks onto b. From then on, z equals b for every accepted bit.
- R6: A locked state persists until a start pulse or a reset.
- R7: A start pulse returns the machine to the tie state. If in_valid is also high in that cycle, that bit is evaluated as the first bit of the new comparison.
- R8: When in_valid is low, the state is held. A comparison can be interrupted by idle cycles and resumed with the same result.
- R9: Over a whole comparison, the output stream equals max(A,B). For example, A=1000 and B=0101 give 1000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Opens a new comparison |
| in_valid | input | 1 | Input bit pair is accepted this cycle |
| a | input | 1 | Bit of operand A, MSB first |
| b | input | 1 | Bit of operand B, MSB first |
| out_valid | output | 1 | z carries a result bit |
| z | output | 1 | Bit of the larger operand |

## Verification
The hardest case to reach is a lock that must survive idle gaps, followed by a new comparison. In that new comparison, start arrives together with a valid bit whose value would have moved the old locked state differently. Random words rarely stay tied long enough to exercise deep-tie prefixes. So the stimulus biases the operands toward equal high bits and inserts random idle cycles and coincident start pulses. Every output bit is checked against a bench model of max(A,B).

// File: rtl/serial_max_sel.sv
module serial_max_sel (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic in_valid,
  input  logic a,
  input  logic b,
  output logic out_valid,
  output logic z
);
  typedef enum logic [1:0] {
    ST_TIE  = 2'b00,
    ST_AWIN = 2'b01,
    ST_BWIN = 2'b10
  } st_t;

  st_t st_q, st_eff, st_d;
  logic z_d;

  assign st_eff = start ? ST_TIE : st_q;

  always_comb begin
    st_d = st_eff;
    z_d  = 1'b0;
    unique case (st_eff)
      ST_AWIN: z_d = a;
      ST_BWIN: z_d = b;
      default: begin
        z_d = a | b;
        if (a && !b) st_d = ST_AWIN;
        else if (!a && b) st_d = ST_BWIN;
        else st_d = ST_TIE;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q      <= ST_TIE;
      out_valid <= 1'b0;
      z         <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        st_q <= st_d;
        z    <= z_d;
      end else if (start) begin
        st_q <= ST_TIE;
      end
    end
  end
endmodule

module serial_max_sel_chk (
  input logic       clk,
  input logic       rst,
  input logic       start,
  input logic       in_valid,
  input logic       a,
  input logic       b,
  input logic       out_valid,
  input logic       z,
  input logic [1:0] st_q
);
  // R1
  reset_clear_chk: assert property (@(posedge clk) rst |=> (!out_valid && st_q == 2'b00));
  // R2
  out_valid_track_chk: assert property (@(posedge clk) disable iff (rst) 1'b1 |=> (out_valid == $past(in_valid)));
  // R4
  a_lock_pass_chk: assert property (@(posedge clk) disable iff (rst)
    (st_q == 2'b01 && !start && in_valid) |=> (z == $past(a)));
  // R5
  b_lock_pass_chk: assert property (@(posedge clk) disable iff (rst)
    (st_q == 2'b10 && !start && in_valid) |=> (z == $past(b)));
  // R6
  lock_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (st_q != 2'b00 && !start) |=> $stable(st_q));
  // R8
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!in_valid && !start) |=> $stable(st_q));
  // R3
  tie_equal_chk: assert property (@(posedge clk) disable iff (rst)
    ((st_q == 2'b00 || start) && in_valid && a == b) |=> (st_q == 2'b00 && z == $past(a)));
  // R1
  legal_state_chk: assert property (@(posedge clk) disable iff (rst) st_q != 2'b11);
endmodule

bind serial_max_sel serial_max_sel_chk chk_i (
  .clk(clk), .rst(rst), .start(start), .in_valid(in_valid),
  .a(a), .b(b), .out_valid(out_valid), .z(z), .st_q(st_q)
);

// File: tb/serial_max_sel_tb.sv
module serial_max_sel_tb_top;
  logic clk = 1'b0;
  logic rst, start, in_valid, a, b;
  logic out_valid, z;
  int checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  serial_max_sel dut_i (
    .clk(clk), .rst(rst), .start(start), .in_valid(in_valid),
    .a(a), .b(b), .out_valid(out_valid), .z(z)
  );

  function automatic logic [15:0] maxf(input logic [15:0] x, input logic [15:0] y);
    return (x > y) ? x : y;
  endfunction

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  // drive one cycle, then sample the registered outputs mid-cycle
  task automatic step(input logic s, input logic v, input logic ai, input logic bi);
    start = s; in_valid = v; a = ai; b = bi;
    @(posedge clk); #1;
    start = 0; in_valid = 0;
  endtask

  // stream two words of width w, optional idle gaps, check each bit
  task automatic run_word(input string req, input logic [15:0] x, input logic [15:0] y,
                          input int w, input bit gaps, input bit idle_start);
    logic [15:0] m;
    m = maxf(x, y);
    for (int i = w - 1; i >= 0; i--) begin
      step(i == w - 1 && !idle_start, 1'b1, x[i], y[i]);
      chk(req, out_valid, 1'b1);
      chk(req, z, m[i]);
      if (gaps && ($urandom % 3 == 0)) begin
        step(1'b0, 1'b0, ~x[i], y[i]);
        chk("R2", out_valid, 1'b0);
      end
    end
  endtask

  initial begin
    #20000000;
    fails++; checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    rst = 1; start = 0; in_valid = 0; a = 0; b = 0;
    repeat (3) @(posedge clk);
    #1;
    chk("R1", out_valid, 1'b0);
    rst = 0;
    run_word("R9", 4'b1000, 4'b0101, 4, 0, 0);
    run_word("R3", 6'b101101, 6'b101101, 6, 0, 0);
    run_word("R4", 5'b10011, 5'b01111, 5, 0, 0);
    run_word("R5", 5'b01000, 5'b10111, 5, 0, 0);
    // R6: locked onto b, then a stream of a=1,b=0 must still follow b
    step(1, 1, 0, 1); chk("R5", z, 1'b1);
    for (int k = 0; k < 4; k++) begin step(0, 1, 1, 0); chk("R6", z, 1'b0); end
    // R7: start alone resets; then a 10 pair locks to a
    step(1, 0, 0, 0); chk("R2", out_valid, 1'b0);
    step(0, 1, 1, 1); chk("R7", z, 1'b1);
    step(0, 1, 1, 0); chk("R7", z, 1'b1);
    step(0, 1, 0, 1); chk("R7", z, 1'b0);
    // R7: start coincident with valid while locked on a
    step(1, 1, 0, 1); chk("R7", z, 1'b1);
    step(0, 1, 1, 0); chk("R7", z, 1'b0);
    // R8: idle gaps with garbage inputs keep the lock
    step(1, 1, 1, 0); chk("R8", z, 1'b1);
    step(0, 0, 0, 1); chk("R8", out_valid, 1'b0);
    step(0, 0, 1, 1);
    step(0, 1, 0, 1); chk("R8", z, 1'b0);
    // reset mid-comparison
    step(1, 1, 0, 1);
    rst = 1; step(0, 0, 0, 0); rst = 0;
    chk("R1", out_valid, 1'b0);
    step(0, 1, 1, 0); chk("R1", z, 1'b1);
    step(0, 1, 0, 1); chk("R1", z, 1'b0);
    // random, biased toward long tied prefixes
    for (int n = 0; n < 300; n++) begin
      logic [15:0] x, y;
      int w, tie;
      w = 1 + ($urandom % 16);
      x = 16'($urandom);
      tie = $urandom % (w + 1);
      y = 16'($urandom);
      for (int j = 0; j < 16; j++) if (j >= w - tie) y[j] = x[j];
      x = x & ((17'h1 << w) - 1);
      y = y & ((17'h1 << w) - 1);
      if ($urandom % 4 == 0) begin
        step(1, 0, 1, 0);
        run_word("R9", x, y, w, 1, 1);
      end else begin
        run_word("R9", x, y, w, 1, 0);
      end
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule